// File: doc/BRIEF.md
# Dual-Port Address Contention Arbiter

This block sits beside a shared two-port memory and watches the left and right ports. Contention exists only when both port enables are high and the two addresses are equal. When contention starts, the arbiter picks one winner. It drives an active-low busy to the losing port and removes that port's write strobe on its way to the array. Reads are never gated.

A mode input selects master or slave. A master runs the arbitration itself and drives its busy outputs as push-pull, active-low levels. A slave takes busy from an external master through dedicated inputs and only applies the write blocking. Its own busy outputs stay idle, so that several devices cascaded for width all block the same port.

Arbitration is a small state machine with three states:
- OWN_NONE: no contention.
- OWN_LEFT: the left port owns the contended location.
- OWN_RIGHT: the right port owns it.

Its transitions are:
- ONSET_LEFT (OWN_NONE to OWN_LEFT): taken on a tie, or when only the left port is the incumbent.
- ONSET_RIGHT (OWN_NONE to OWN_RIGHT): taken when only the right port is the incumbent.
- HOLD (OWN_LEFT to OWN_LEFT, OWN_RIGHT to OWN_RIGHT): taken while the match persists.
- RELEASE (OWN_LEFT or OWN_RIGHT back to OWN_NONE): taken once the match ends.

A port is the incumbent when it was enabled in the previous cycle at the address it presents now. All outputs are combinational in the current inputs and the registered state. The storage array itself is not part of this block.

Top module: `dualport_contend_arb`

## Requirements
- R1: A match means both enables are 1 and the addresses are equal. With no match, both busy outputs are 1 (busy is active low: 0 means busy).
- R2: In master mode (master_sel = 1), a match drives exactly one busy output to 0 and the other to 1.
- R3: When a match begins and neither port, or both ports, held the matched address in the previous cycle, the left port wins and rt_busy_out_n is 0.
- R4: When a match begins and only the right port was enabled at the same address in the previous cycle, the right port wins and lt_busy_out_n is 0.
- R5: While the match persists from cycle to cycle, the winner chosen at its onset is kept. This holds even if the loser later becomes an incumbent, or stops writing.
- R6: In the first cycle with no match, both busy outputs return to 1 and the writes of both ports pass.
- R7: In master mode, each port's gated write equals its enable AND its write AND its own busy output (1 when not busy).
- R8: In slave mode (master_sel = 0), both busy outputs are held at 1. Each port's gated write equals its enable AND its write AND its busy input, whatever the addresses are.
- R9: In master mode, the busy inputs have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| master_sel | input | 1 | 1 = master (arbitrate), 0 = slave (import busy) |
| lt_en | input | 1 | Left port enable |
| lt_addr | input | ADDR_W | Left port address |
| lt_wr | input | 1 | Left port write request |
| rt_en | input | 1 | Right port enable |
| rt_addr | input | ADDR_W | Right port address |
| rt_wr | input | 1 | Right port write request |
| lt_busy_in_n | input | 1 | Left busy from external master, active low (slave mode) |
| rt_busy_in_n | input | 1 | Right busy from external master, active low (slave mode) |
| lt_busy_out_n | output | 1 | Left busy result, active low (master mode) |
| rt_busy_out_n | output | 1 | Right busy result, active low (master mode) |
| lt_wr_gated | output | 1 | Left write strobe to the array after blocking |
| rt_wr_gated | output | 1 | Right write strobe to the array after blocking |

## Verification
The bench starts contention from a fresh tie, where a design without the left bias would hand the location to the right port. It also starts contention with the right port already holding the address, where a design that ignores incumbency would steal the location from its holder. It then keeps a match alive while the loser becomes an incumbent, which exposes a design that re-arbitrates every cycle and flips the winner, and it ends contention to catch a busy that lingers one cycle. Slave and master mode are both driven with busy inputs low, which exposes a slave that still applies its own arbitration or a master that obeys the imported busy.

// File: rtl/dpc_pkg.sv
package dpc_pkg;

    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } own_state_t;

    localparam int NUM_PORTS = 2;
    localparam int PORT_L    = 0;
    localparam int PORT_R    = 1;

endpackage

// File: rtl/dpc_incumbency.sv
module dpc_incumbency #(
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [ADDR_W-1:0] addr,
    output logic              held
);

    logic              en_q;
    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            addr_q <= '0;
        end else begin
            en_q   <= en;
            addr_q <= addr;
        end
    end

    // The port was already sitting on this address in the previous cycle.
    assign held = en && en_q && (addr == addr_q);

endmodule

// File: rtl/dpc_owner_fsm.sv
module dpc_owner_fsm
    import dpc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic match,
    input  logic l_held,
    input  logic r_held,
    output logic win_left,
    output logic win_right
);

    own_state_t state_q, state_d;
    logic       onset_right;

    // The right port wins the onset only as the sole incumbent; a tie goes left.
    assign onset_right = r_held && !l_held;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= OWN_NONE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OWN_NONE: begin
                if (match) state_d = onset_right ? OWN_RIGHT : OWN_LEFT; // ONSET_RIGHT / ONSET_LEFT
            end
            OWN_LEFT: begin
                if (!match) state_d = OWN_NONE;                            // RELEASE, else HOLD
            end
            OWN_RIGHT: begin
                if (!match) state_d = OWN_NONE;                            // RELEASE, else HOLD
            end
            default: state_d = OWN_NONE;
        endcase
    end

    always_comb begin
        win_left  = 1'b0;
        win_right = 1'b0;
        if (match) begin
            unique case (state_q)
                OWN_NONE: begin
                    win_left  = !onset_right;
                    win_right = onset_right;
                end
                OWN_LEFT:  win_left  = 1'b1;
                OWN_RIGHT: win_right = 1'b1;
                default: begin
                    win_left  = 1'b0;
                    win_right = 1'b0;
                end
            endcase
        end
    end

    // R5: ownership never passes directly from one port to the other.
    p_no_swap_l_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == OWN_LEFT) |=> (state_q != OWN_RIGHT));
    p_no_swap_r_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == OWN_RIGHT) |=> (state_q != OWN_LEFT));

endmodule

// File: rtl/dpc_write_gate.sv
module dpc_write_gate (
    input  logic en,
    input  logic wr,
    input  logic blocked,
    output logic wr_out
);

    assign wr_out = en && wr && !blocked;

endmodule

// File: rtl/dualport_contend_arb.sv
module dualport_contend_arb
    import dpc_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_sel,
    input  logic              lt_en,
    input  logic [ADDR_W-1:0] lt_addr,
    input  logic              lt_wr,
    input  logic              rt_en,
    input  logic [ADDR_W-1:0] rt_addr,
    input  logic              rt_wr,
    input  logic              lt_busy_in_n,
    input  logic              rt_busy_in_n,
    output logic              lt_busy_out_n,
    output logic              rt_busy_out_n,
    output logic              lt_wr_gated,
    output logic              rt_wr_gated
);

    logic              en_v      [NUM_PORTS];
    logic [ADDR_W-1:0] addr_v    [NUM_PORTS];
    logic              wr_v      [NUM_PORTS];
    logic              held_v    [NUM_PORTS];
    logic              blk_v     [NUM_PORTS];
    logic              gated_v   [NUM_PORTS];
    logic              busyin_v  [NUM_PORTS];
    logic              lose_v    [NUM_PORTS];
    logic              match;
    logic              win_left, win_right;

    assign en_v[PORT_L]     = lt_en;
    assign en_v[PORT_R]     = rt_en;
    assign addr_v[PORT_L]   = lt_addr;
    assign addr_v[PORT_R]   = rt_addr;
    assign wr_v[PORT_L]     = lt_wr;
    assign wr_v[PORT_R]     = rt_wr;
    assign busyin_v[PORT_L] = lt_busy_in_n;
    assign busyin_v[PORT_R] = rt_busy_in_n;

    assign match = lt_en && rt_en && (lt_addr == rt_addr);

    dpc_owner_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .match     (match),
        .l_held    (held_v[PORT_L]),
        .r_held    (held_v[PORT_R]),
        .win_left  (win_left),
        .win_right (win_right)
    );

    assign lose_v[PORT_L] = win_right;
    assign lose_v[PORT_R] = win_left;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        dpc_incumbency #(.ADDR_W(ADDR_W)) u_inc (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (en_v[p]),
            .addr  (addr_v[p]),
            .held  (held_v[p])
        );

        // A master blocks on its own verdict, a slave on the imported busy.
        assign blk_v[p] = master_sel ? lose_v[p] : !busyin_v[p];

        dpc_write_gate u_gate (
            .en      (en_v[p]),
            .wr      (wr_v[p]),
            .blocked (blk_v[p]),
            .wr_out  (gated_v[p])
        );
    end

    assign lt_busy_out_n = master_sel ? !lose_v[PORT_L] : 1'b1;
    assign rt_busy_out_n = master_sel ? !lose_v[PORT_R] : 1'b1;
    assign lt_wr_gated   = gated_v[PORT_L];
    assign rt_wr_gated   = gated_v[PORT_R];

    p_idle_no_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(lt_en && rt_en && (lt_addr == rt_addr)) |-> (lt_busy_out_n && rt_busy_out_n));

    p_one_loser_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (master_sel && lt_en && rt_en && (lt_addr == rt_addr)) |-> (lt_busy_out_n != rt_busy_out_n));

    p_keep_owner_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (master_sel && match && $past(rst_n) && $past(master_sel) && $past(match))
        |-> $stable(lt_busy_out_n));

    p_gate_left_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (master_sel && !lt_busy_out_n) |-> !lt_wr_gated);

    p_gate_right_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (master_sel && !rt_busy_out_n) |-> !rt_wr_gated);

    p_slave_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !master_sel |-> (lt_busy_out_n && rt_busy_out_n));

    p_slave_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!master_sel && (!lt_busy_in_n || !rt_busy_in_n))
        |-> !((!lt_busy_in_n && lt_wr_gated) || (!rt_busy_in_n && rt_wr_gated)));

endmodule

// File: tb/dualport_contend_arb_test.sv
module dualport_contend_arb_test;

    localparam int AW = 14;

    typedef struct {
        logic  lb;
        logic  rb;
        logic  lg;
        logic  rg;
        string tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          master_sel;
    logic          lt_en, rt_en, lt_wr, rt_wr;
    logic [AW-1:0] lt_addr, rt_addr;
    logic          lt_busy_in_n, rt_busy_in_n;
    logic          lt_busy_out_n, rt_busy_out_n, lt_wr_gated, rt_wr_gated;

    int   checks = 0;
    int   errors = 0;
    exp_t sb_q[$];
    bit   drv_done = 1'b0;

    // reference model state: 0 none, 1 left owns, 2 right owns
    int          m_owner = 0;
    bit          m_ple   = 1'b0;
    bit          m_pre   = 1'b0;
    logic [AW-1:0] m_pla = '0;
    logic [AW-1:0] m_pra = '0;

    always #10 clk = ~clk;

    dualport_contend_arb #(.ADDR_W(AW)) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .master_sel    (master_sel),
        .lt_en         (lt_en),
        .lt_addr       (lt_addr),
        .lt_wr         (lt_wr),
        .rt_en         (rt_en),
        .rt_addr       (rt_addr),
        .rt_wr         (rt_wr),
        .lt_busy_in_n  (lt_busy_in_n),
        .rt_busy_in_n  (rt_busy_in_n),
        .lt_busy_out_n (lt_busy_out_n),
        .rt_busy_out_n (rt_busy_out_n),
        .lt_wr_gated   (lt_wr_gated),
        .rt_wr_gated   (rt_wr_gated)
    );

    task automatic step(input bit ms, input bit le, input logic [AW-1:0] la, input bit lw,
                        input bit re, input logic [AW-1:0] ra, input bit rw,
                        input bit lbi, input bit rbi, input string tag);
        exp_t e;
        bit   match, lheld, rheld;
        int   win;
        @(negedge clk);
        master_sel = ms; lt_en = le; lt_addr = la; lt_wr = lw;
        rt_en = re; rt_addr = ra; rt_wr = rw;
        lt_busy_in_n = lbi; rt_busy_in_n = rbi;
        match = le && re && (la == ra);
        lheld = le && m_ple && (la == m_pla);
        rheld = re && m_pre && (ra == m_pra);
        if (!match)          win = 0;
        else if (m_owner != 0) win = m_owner;
        else                 win = (rheld && !lheld) ? 2 : 1;
        if (ms) begin
            e.lb = !(win == 2);
            e.rb = !(win == 1);
            e.lg = le && lw && e.lb;
            e.rg = re && rw && e.rb;
        end else begin
            e.lb = 1'b1;
            e.rb = 1'b1;
            e.lg = le && lw && lbi;
            e.rg = re && rw && rbi;
        end
        e.tag = tag;
        sb_q.push_back(e);
        m_owner = win;
        m_ple = le; m_pla = la; m_pre = re; m_pra = ra;
    endtask

    // monitor: samples two ns before each rising edge
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            #8;
            if (sb_q.size() != 0) begin
                e = sb_q.pop_front();
                checks++;
                if ({lt_busy_out_n, rt_busy_out_n, lt_wr_gated, rt_wr_gated} !== {e.lb, e.rb, e.lg, e.rg}) begin
                    errors++;
                    $display("FAIL %s: got lb=%b rb=%b lg=%b rg=%b expected lb=%b rb=%b lg=%b rg=%b",
                             e.tag, lt_busy_out_n, rt_busy_out_n, lt_wr_gated, rt_wr_gated,
                             e.lb, e.rb, e.lg, e.rg);
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; master_sel = 1'b1;
        lt_en = 0; rt_en = 0; lt_wr = 0; rt_wr = 0; lt_addr = '0; rt_addr = '0;
        lt_busy_in_n = 1; rt_busy_in_n = 1;
        repeat (3) @(negedge clk);
        #8;
        checks++;
        if ({lt_busy_out_n, rt_busy_out_n, lt_wr_gated, rt_wr_gated} !== 4'b1100) begin
            errors++;
            $display("FAIL reset R1: got %b expected 1100",
                     {lt_busy_out_n, rt_busy_out_n, lt_wr_gated, rt_wr_gated});
        end
        @(negedge clk); rst_n = 1'b1;

        step(1, 1, 14'd5, 1, 1, 14'd6, 1, 1, 1, "R1 R7 distinct addresses");
        step(1, 1, 14'd7, 1, 1, 14'd7, 1, 1, 1, "R3 fresh tie left wins");
        step(1, 1, 14'd7, 1, 1, 14'd7, 1, 1, 1, "R5 hold left with both incumbent");
        step(1, 1, 14'd7, 1, 1, 14'd7, 0, 1, 1, "R5 hold left while right reads");
        step(1, 1, 14'd7, 1, 1, 14'd8, 1, 1, 1, "R6 release");
        step(1, 0, 14'd9, 1, 1, 14'd9, 1, 1, 1, "R1 left disabled same address");
        step(1, 1, 14'd9, 1, 1, 14'd9, 1, 1, 1, "R4 right incumbent wins");
        step(1, 1, 14'd9, 1, 1, 14'd9, 1, 1, 1, "R5 hold right");
        step(1, 0, 14'd9, 1, 1, 14'd9, 1, 1, 1, "R6 release on enable drop");
        step(1, 1, 14'd3, 1, 1, 14'd3, 1, 1, 1, "R3 tie from idle");
        step(1, 1, 14'd10, 1, 1, 14'd11, 1, 1, 1, "R2 no match no loser");
        step(0, 1, 14'd12, 1, 1, 14'd12, 1, 0, 1, "R8 slave imports left busy");
        step(0, 1, 14'd1, 1, 1, 14'd2, 1, 1, 0, "R8 slave blocks without match");
        step(1, 1, 14'd1, 1, 1, 14'd2, 1, 0, 0, "R9 master ignores busy inputs");
        step(1, 1, 14'd4, 1, 1, 14'd4, 1, 0, 0, "R9 R2 master match ignores busy inputs");
        step(1, 0, 14'd4, 1, 1, 14'd4, 1, 1, 1, "R6 release after imported-ignored match");
        step(1, 1, 14'h2000, 1, 1, 14'h0000, 1, 1, 1, "R1 top address bit differs");
        step(1, 1, 14'd6, 0, 1, 14'd6, 1, 1, 1, "R3 R7 left wins tie while reading");

        drv_done = 1'b1;
        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule